// File: doc/BRIEF.md
# Running-Average Reference Memory

This block supplies the gain-invariant reference used by a rational dither modulation quantizer. Coefficients arrive one per clock, each tagged with its position inside a frame and carrying the freshly produced output value for that position. For every such request the block returns the current mean of the last 16 output values seen at that position, and then folds the new value into that mean.

State is kept in two register files: a history of 16 frame slots by `NPOS` positions holding past outputs, and a per-position average store. The average is never re-summed. It is adjusted in one step by scaling the old mean by 16, adding the new value, subtracting the value that drops out of the 16-frame window, and scaling back by 16. Both scalings are bit shifts. A frame slot pointer selects which history slot is the oldest. A forwarding path lets requests to the same position on consecutive cycles see each other's results.

Values are signed two's complement with 8 fractional bits, 25 bits wide by default (17 integer bits including sign, 8 fractional bits).

Top module: `ravg_ref_mem`

## Requirements
- R1: After reset every average entry and every history entry holds the value 1.0 (integer code 256 with 8 fractional bits), so the first reference returned for any position is 256.
- R2: `ref_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R3: `ref_avg` carries the average of the requested position as it stood before that request's own update.
- R4: The updated average equals floor((16*old_average + new_value - oldest_value) / 16), formed in a sum at least 5 bits wider than the data word and then cut to the data width in two's complement.
- R5: The oldest value is the entry held at the current frame slot for the requested position, and the new value replaces exactly that entry; an entry never written reads 256.
- R6: The 4-bit frame slot pointer starts at 0 and advances by one, wrapping from 15 to 0, only on an accepted request whose position is `NPOS-1`; requests to other positions keep the same slot.
- R7: Requests to the same position on consecutive cycles, including several in a row, return references and perform updates identical to those they would have with idle cycles between them.
- R8: A cycle with `req_valid` low changes no average, no history entry and no slot pointer.
- R9: An update touches only the average and history of the requested position; other positions keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_pos | input | 7 | Coefficient position within the frame |
| req_val | input | 25 | New output value for the position, signed, 8 fractional bits |
| ref_valid | output | 1 | `ref_avg` holds the reference for last cycle's request |
| ref_avg | output | 25 | Reference average before the request's update, signed, 8 fractional bits |

## Verification
The bench runs a four-position configuration and compares every reference against an arithmetic model of the recursive update. In-order frame sweeps with mixed-sign values over more than two full windows show whether the oldest value is taken from the right slot and whether the frame pointer wraps; repeated and out-of-order positions, including runs of the last position, separate forwarding faults and wrong pointer stepping from a correct window. Idle gaps and long runs on a single position show whether anything moves without a request or leaks between positions, and full-scale positive and negative values expose a guard width that is too narrow in the sum.

// File: rtl/ravg_pkg.sv
package ravg_pkg;
  localparam int unsigned DEF_NPOS   = 128;
  localparam int unsigned DEF_FRAMES = 16;
  localparam int unsigned DEF_DATA_W = 25;
  localparam int unsigned DEF_FRAC_W = 8;

  // Fixed-point code for the value 1.0 in a word of the given width.
  function automatic logic [63:0] fx_one(input int unsigned frac_w);
    return 64'd1 << frac_w;
  endfunction
endpackage

// File: rtl/ravg_regfile.sv
module ravg_regfile #(
  parameter int unsigned W     = 25,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter logic [W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  // Storage: every entry resets to the initial value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Synchronous read port; a write to the same entry at the same edge
  // is not visible here (old data), the caller forwards around it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= INIT;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ravg_frame_ctr.sv
module ravg_frame_ctr #(
  parameter int unsigned FRAMES = 16,
  parameter int unsigned NPOS   = 128,
  localparam int unsigned PTR_W = $clog2(FRAMES),
  localparam int unsigned POS_W = $clog2(NPOS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [POS_W-1:0] pos,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             adv;

  assign adv = step_en && (pos == POS_W'(NPOS - 1));

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/ravg_update.sv
module ravg_update #(
  parameter int unsigned DATA_W = 25,
  parameter int unsigned SH     = 4,
  localparam int unsigned SW    = DATA_W + SH + 1
) (
  input  logic [DATA_W-1:0] avg_old,
  input  logic [DATA_W-1:0] y_new,
  input  logic [DATA_W-1:0] y_oldest,
  output logic [DATA_W-1:0] avg_new
);
  logic signed [SW-1:0] scaled, add_t, sub_t, sum;

  always_comb begin
    // Sign-extend into the wide sum; the scaled term is the old mean
    // times the window length, done as a left shift.
    scaled = signed'({{(SH + 1){avg_old[DATA_W-1]}}, avg_old}) <<< SH;
    add_t  = signed'({{(SH + 1){y_new[DATA_W-1]}}, y_new});
    sub_t  = signed'({{(SH + 1){y_oldest[DATA_W-1]}}, y_oldest});
    sum    = scaled + add_t - sub_t;
  end

  // Divide by the window length: arithmetic right shift, then cut to width.
  assign avg_new = sum[SH +: DATA_W];
endmodule

// File: rtl/ravg_ref_mem.sv
module ravg_ref_mem #(
  parameter int unsigned NPOS   = ravg_pkg::DEF_NPOS,
  parameter int unsigned FRAMES = ravg_pkg::DEF_FRAMES,
  parameter int unsigned DATA_W = ravg_pkg::DEF_DATA_W,
  parameter int unsigned FRAC_W = ravg_pkg::DEF_FRAC_W,
  localparam int unsigned POS_W = $clog2(NPOS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [POS_W-1:0]  req_pos,
  input  logic [DATA_W-1:0] req_val,
  output logic              ref_valid,
  output logic [DATA_W-1:0] ref_avg
);
  localparam int unsigned PTR_W   = $clog2(FRAMES);
  localparam int unsigned HDEPTH  = FRAMES * NPOS;
  localparam int unsigned HAW     = PTR_W + POS_W;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(ravg_pkg::fx_one(FRAC_W));

  // Frame slot pointer
  logic [PTR_W-1:0] ptr;

  ravg_frame_ctr #(.FRAMES(FRAMES), .NPOS(NPOS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_en(req_valid), .pos(req_pos), .ptr(ptr)
  );

  // Stage-1 (update) registers
  logic              s1_valid_q, s1_valid_d;
  logic [POS_W-1:0]  s1_pos_q,   s1_pos_d;
  logic [PTR_W-1:0]  s1_ptr_q,   s1_ptr_d;
  logic [DATA_W-1:0] s1_val_q,   s1_val_d;
  logic              fa_sel_q,   fa_sel_d;
  logic [DATA_W-1:0] fa_val_q,   fa_val_d;
  logic              fh_sel_q,   fh_sel_d;
  logic [DATA_W-1:0] fh_val_q,   fh_val_d;

  logic [DATA_W-1:0] avg_rd, hist_rd, avg_old, y_oldest, avg_new;
  logic              hit_avg, hit_hist;

  // Memories
  ravg_regfile #(.W(DATA_W), .DEPTH(NPOS), .AW(POS_W), .INIT(ONE)) u_avg (
    .clk(clk), .rst_n(rst_n),
    .rd_en(req_valid), .rd_addr(req_pos), .rd_data(avg_rd),
    .wr_en(s1_valid_q), .wr_addr(s1_pos_q), .wr_data(avg_new)
  );

  ravg_regfile #(.W(DATA_W), .DEPTH(HDEPTH), .AW(HAW), .INIT(ONE)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_en(req_valid), .rd_addr({ptr, req_pos}), .rd_data(hist_rd),
    .wr_en(s1_valid_q), .wr_addr({s1_ptr_q, s1_pos_q}), .wr_data(s1_val_q)
  );

  // Forward-corrected operands for the update
  assign avg_old  = fa_sel_q ? fa_val_q : avg_rd;
  assign y_oldest = fh_sel_q ? fh_val_q : hist_rd;

  ravg_update #(.DATA_W(DATA_W), .SH(PTR_W)) u_upd (
    .avg_old(avg_old), .y_new(s1_val_q), .y_oldest(y_oldest), .avg_new(avg_new)
  );

  // A request colliding with the entry being written this edge
  assign hit_avg  = s1_valid_q && req_valid && (req_pos == s1_pos_q);
  assign hit_hist = hit_avg && (ptr == s1_ptr_q);

  always_comb begin
    s1_valid_d = req_valid;
    s1_pos_d   = s1_pos_q;
    s1_ptr_d   = s1_ptr_q;
    s1_val_d   = s1_val_q;
    fa_sel_d   = fa_sel_q;
    fa_val_d   = fa_val_q;
    fh_sel_d   = fh_sel_q;
    fh_val_d   = fh_val_q;
    if (req_valid) begin
      s1_pos_d = req_pos;
      s1_ptr_d = ptr;
      s1_val_d = req_val;
      fa_sel_d = hit_avg;
      fa_val_d = avg_new;
      fh_sel_d = hit_hist;
      fh_val_d = s1_val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_pos_q   <= '0;
      s1_ptr_q   <= '0;
      s1_val_q   <= '0;
      fa_sel_q   <= 1'b0;
      fa_val_q   <= '0;
      fh_sel_q   <= 1'b0;
      fh_val_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_pos_q   <= s1_pos_d;
      s1_ptr_q   <= s1_ptr_d;
      s1_val_q   <= s1_val_d;
      fa_sel_q   <= fa_sel_d;
      fa_val_q   <= fa_val_d;
      fh_sel_q   <= fh_sel_d;
      fh_val_q   <= fh_val_d;
    end
  end

  assign ref_valid = s1_valid_q;
  assign ref_avg   = avg_old;

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ref_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ref_valid);
  assert_back_to_back_sees_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_avg |=> (ref_avg == $past(avg_new)));
  assert_oldest_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hist |=> (y_oldest == $past(s1_val_q)));
endmodule

// File: tb/ravg_ref_mem_test.sv
`timescale 1ns/1ps
module ravg_ref_mem_test;
  localparam int unsigned NP   = 4;
  localparam int unsigned FR   = 16;
  localparam int unsigned DW   = 25;
  localparam int unsigned FW   = 8;
  localparam int unsigned PW   = $clog2(NP);
  localparam longint      ONEV = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [PW-1:0] req_pos;
  logic [DW-1:0] req_val;
  logic          ref_valid;
  logic [DW-1:0] ref_avg;

  ravg_ref_mem #(.NPOS(NP), .FRAMES(FR), .DATA_W(DW), .FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pos(req_pos),
    .req_val(req_val), .ref_valid(ref_valid), .ref_avg(ref_avg)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  longint mh [FR][NP];
  longint ma [NP];
  int     mptr;

  bit     pend_v = 1'b0;
  longint pend_exp;
  string  pend_tag;

  function automatic longint wrap(input longint v);
    longint m;
    m = v & ((64'sd1 <<< DW) - 1);
    if (m[DW-1]) m = m - (64'sd1 <<< DW);
    return m;
  endfunction

  task automatic model_upd(input int p, input longint y);
    longint s;
    s = ma[p] * 16 + y - mh[mptr][p];
    ma[p] = wrap(s >>> 4);
    mh[mptr][p] = y;
    if (p == NP - 1) mptr = (mptr + 1) % FR;
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: check last cycle's request, then present this cycle's.
  task automatic cyc(input bit v, input int p, input longint y, input string tag);
    longint got;
    @(negedge clk);
    check("R2 ref_valid", longint'(ref_valid), longint'(pend_v));
    if (pend_v) begin
      got = longint'($signed(ref_avg));
      check(pend_tag, got, pend_exp);
    end
    req_valid = v;
    req_pos   = PW'(p);
    req_val   = DW'(y);
    pend_v    = v;
    if (v) begin
      pend_exp = ma[p];
      pend_tag = tag;
      model_upd(p, y);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int f = 0; f < FR; f++)
      for (int p = 0; p < NP; p++) mh[f][p] = ONEV;
    for (int p = 0; p < NP; p++) ma[p] = ONEV;
    mptr = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_pos = '0;
    req_val = '0;
    repeat (3) @(negedge clk);
    check("R1 ref_valid in reset", longint'(ref_valid), 0);
    rst_n = 1'b1;

    // R1: every position first reports 1.0
    for (int p = 0; p < NP; p++) cyc(1'b1, p, ONEV, "R1 initial reference");
    check("R1 first reference code", pend_exp, ONEV);

    // R3/R4/R5/R6: in-order frames, mixed signs, more than two windows
    for (int f = 0; f < 40; f++)
      for (int p = 0; p < NP; p++)
        cyc(1'b1, p, longint'((f * 37 + p * 101) % 700) * 13 - 4500, "R4 sweep update");

    // R7: same position back to back, including runs of the last position
    for (int k = 0; k < 6; k++) cyc(1'b1, 2, longint'(k * 1111 - 2000), "R7 repeat pos2");
    for (int k = 0; k < 20; k++) cyc(1'b1, NP - 1, longint'(k * 333 - 3000), "R6 repeat last pos");
    for (int k = 0; k < 30; k++) cyc(1'b1, (k * 3) % NP, longint'(k * 71 - 900), "R7 mixed order");

    // R5/R6: one position only, same slot rewritten within a frame
    for (int k = 0; k < 24; k++) cyc(1'b1, 0, longint'(k * 16 + 40), "R6 slot held");

    // R8: idle gaps between requests
    for (int k = 0; k < 12; k++) begin
      cyc(1'b0, k % NP, 64'sd99999, "R8 idle");
      cyc(1'b0, 1, -64'sd77777, "R8 idle");
      cyc(1'b1, k % NP, longint'(k * 500 - 2500), "R8 after idle");
    end

    // R9: long run on position 1, then the others must be unchanged
    for (int k = 0; k < 40; k++) cyc(1'b1, 1, longint'(k * 200 + 5), "R9 run pos1");
    cyc(1'b1, 0, 0, "R9 pos0 untouched");
    cyc(1'b1, 2, 0, "R9 pos2 untouched");

    // R4: full-scale values exercise the guard bits
    for (int k = 0; k < 40; k++)
      cyc(1'b1, k % NP, (k % 3 == 0) ? -(64'sd1 <<< (DW - 1))
                                      : (64'sd1 <<< (DW - 1)) - 1, "R4 full scale");
    for (int k = 0; k < 70; k++)
      cyc(1'b1, k % NP, (k % 2 == 0) ? (64'sd1 <<< (DW - 1)) - 1
                                      : -(64'sd1 <<< (DW - 1)), "R4 alternating extremes");

    // R3: final references after all activity
    for (int p = 0; p < NP; p++) cyc(1'b1, p, 0, "R3 final reference");
    cyc(1'b0, 0, 0, "R2 drain");
    cyc(1'b0, 0, 0, "R2 drain");
    finish_run();
  end
endmodule